// File: doc/BRIEF.md
# Dual-Port Memory with Mailbox Interrupts

This block is a synchronous two-port word memory. A left port and a right port each have their own address, write data, read data, active-low chip enable, active-low output enable and a read/write select. Both ports may access the memory in the same clock cycle. Each access completes on the rising clock edge. Read data comes from a register, and a separate drive-enable output marks the cycles in which a port's read bus would be driven.

The two highest addresses also act as mailboxes between the ports. When the right port writes the address just below the top, a flag is raised toward the left port. The left port lowers that flag by reading the same address. The topmost address does the same job in the other direction. Both flags appear as active-low interrupt outputs. A mailbox address also keeps its written word, like any other location, so one write passes both a message and a doorbell.

Top module: `dp_mailbox_ram`

## Requirements
- R1: While `rst` is high, and in the cycle after it is released, both interrupt outputs are high (inactive) and both drive-enable outputs are low.
- R2: An access with chip enable low (0) and `rw` low (0 = write) at a rising edge stores the write data at that port's address.
- R3: An access with chip enable low and `rw` high (1 = read) at an edge loads the word at that address into the port's read-data output after the edge. The drive-enable output is high after that edge only if output enable was also low (0).
- R4: The drive-enable output is low after any edge where the port's access was not an output-enabled read: a write, chip enable high, or output enable high.
- R5: The two ports work independently in the same cycle. A read on one port of the address that the other port writes at the same edge returns the word stored before that edge.
- R6: A right-port write to address 0x1FFE drives `l_int_n` low after that edge.
- R7: A left-port read of address 0x1FFE drives `l_int_n` high after that edge, whatever the output-enable level.
- R8: A left-port write to address 0x1FFF drives `r_int_n` low after that edge. A right-port read of 0x1FFF drives it high again.
- R9: Nothing else changes the interrupt outputs. This includes a port writing its own mailbox address and a port reading the other port's mailbox address.
- R10: If a flag is set and cleared in the same cycle, it ends up set (interrupt low).
- R11: The mailbox addresses store their written data, and a read returns that data, like any other location.
- R12: A write presented with chip enable high leaves the memory unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both ports |
| rst | input | 1 | Synchronous reset, active high; clears the interrupt flags and drive enables |
| l_ce_n | input | 1 | Left chip enable, active low |
| l_oe_n | input | 1 | Left output enable, active low |
| l_rw | input | 1 | Left direction: 1 read, 0 write |
| l_addr | input | ADDR_W | Left address |
| l_wdata | input | DATA_W | Left write data |
| l_rdata | output | DATA_W | Left read data, registered |
| l_drive | output | 1 | Left read bus is driven (high) or released (low) |
| l_int_n | output | 1 | Interrupt toward the left port, active low |
| r_ce_n | input | 1 | Right chip enable, active low |
| r_oe_n | input | 1 | Right output enable, active low |
| r_rw | input | 1 | Right direction: 1 read, 0 write |
| r_addr | input | ADDR_W | Right address |
| r_wdata | input | DATA_W | Right write data |
| r_rdata | output | DATA_W | Right read data, registered |
| r_drive | output | 1 | Right read bus is driven (high) or released (low) |
| r_int_n | output | 1 | Interrupt toward the right port, active low |

## Verification
The bench checks that each flag responds only to the correct pairing of port, direction and address. A design with the mailbox addresses swapped, or one that set a flag on its own port's write, would change the wrong interrupt output. It checks that a clearing read works with output enable high, which catches a design that tied clearing to the driven bus. It checks that a set and a clear in the same cycle leave the flag raised; a design that favoured the clear would miss the new message. It also checks same-edge reads and writes across the ports, which expose a design that forwards new write data, and checks that a write with chip enable high is ignored.

// File: rtl/dp_mailbox_ram.sv
module dp_mailbox_ram #(
  parameter int ADDR_W = 13,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              l_ce_n,
  input  logic              l_oe_n,
  input  logic              l_rw,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic [DATA_W-1:0] l_wdata,
  output logic [DATA_W-1:0] l_rdata,
  output logic              l_drive,
  output logic              l_int_n,
  input  logic              r_ce_n,
  input  logic              r_oe_n,
  input  logic              r_rw,
  input  logic [ADDR_W-1:0] r_addr,
  input  logic [DATA_W-1:0] r_wdata,
  output logic [DATA_W-1:0] r_rdata,
  output logic              r_drive,
  output logic              r_int_n
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam logic [ADDR_W-1:0] MB_R = {ADDR_W{1'b1}};
  localparam logic [ADDR_W-1:0] MB_L = MB_R - 1'b1;

  logic [DATA_W-1:0] mem [DEPTH];
  logic l_flag, r_flag;

  wire l_wr = !l_ce_n && !l_rw;
  wire l_rd = !l_ce_n &&  l_rw;
  wire r_wr = !r_ce_n && !r_rw;
  wire r_rd = !r_ce_n &&  r_rw;

  wire l_set = r_wr && (r_addr == MB_L);
  wire l_clr = l_rd && (l_addr == MB_L);
  wire r_set = l_wr && (l_addr == MB_R);
  wire r_clr = r_rd && (r_addr == MB_R);

  always_ff @(posedge clk) begin
    if (l_rd) l_rdata <= mem[l_addr];
    if (r_rd) r_rdata <= mem[r_addr];
    if (l_wr) mem[l_addr] <= l_wdata;
    if (r_wr) mem[r_addr] <= r_wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      l_flag  <= 1'b0;
      r_flag  <= 1'b0;
      l_drive <= 1'b0;
      r_drive <= 1'b0;
    end else begin
      l_flag  <= l_set || (l_flag && !l_clr);
      r_flag  <= r_set || (r_flag && !r_clr);
      l_drive <= l_rd && !l_oe_n;
      r_drive <= r_rd && !r_oe_n;
    end
  end

  assign l_int_n = !l_flag;
  assign r_int_n = !r_flag;

  assert_l_set_R6: assert property (@(posedge clk) disable iff (rst)
    (!r_ce_n && !r_rw && r_addr == MB_L) |=> !l_int_n);
  assert_l_clr_R7: assert property (@(posedge clk) disable iff (rst)
    (!l_ce_n && l_rw && l_addr == MB_L && !(!r_ce_n && !r_rw && r_addr == MB_L)) |=> l_int_n);
  assert_r_set_R8: assert property (@(posedge clk) disable iff (rst)
    (!l_ce_n && !l_rw && l_addr == MB_R) |=> !r_int_n);
  assert_l_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !((!r_ce_n && !r_rw && r_addr == MB_L) || (!l_ce_n && l_rw && l_addr == MB_L))
    |=> $stable(l_int_n));
  assert_r_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !((!l_ce_n && !l_rw && l_addr == MB_R) || (!r_ce_n && r_rw && r_addr == MB_R))
    |=> $stable(r_int_n));
  assert_drive_on_R3: assert property (@(posedge clk) disable iff (rst)
    (!l_ce_n && !l_oe_n && l_rw) |=> l_drive);
  assert_drive_off_R4: assert property (@(posedge clk) disable iff (rst)
    !(!r_ce_n && !r_oe_n && r_rw) |=> !r_drive);
endmodule

// File: tb/sim_dp_mailbox_ram.sv
module sim_dp_mailbox_ram;
  logic clk = 0, rst = 1;
  logic l_ce_n = 1, l_oe_n = 1, l_rw = 1, r_ce_n = 1, r_oe_n = 1, r_rw = 1;
  logic [12:0] l_addr = 0, r_addr = 0;
  logic [7:0] l_wdata = 0, r_wdata = 0;
  logic [7:0] l_rdata, r_rdata;
  logic l_drive, r_drive, l_int_n, r_int_n;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  dp_mailbox_ram u0 (.*);

  task automatic chk(string req, logic [7:0] got, logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic setl(bit ce, bit oe, bit rw, logic [12:0] a, logic [7:0] d);
    l_ce_n = !ce; l_oe_n = !oe; l_rw = rw; l_addr = a; l_wdata = d;
  endtask

  task automatic setr(bit ce, bit oe, bit rw, logic [12:0] a, logic [7:0] d);
    r_ce_n = !ce; r_oe_n = !oe; r_rw = rw; r_addr = a; r_wdata = d;
  endtask

  task automatic idle();
    setl(0, 0, 1, 0, 0); setr(0, 0, 1, 0, 0);
  endtask

  task automatic t_reset();
    chk("R1 l_int_n", l_int_n, 1); chk("R1 r_int_n", r_int_n, 1);
    rst = 0; idle(); tick();
    chk("R1 l_drive", l_drive, 0); chk("R1 r_drive", r_drive, 0);
    chk("R1 l_int_n after", l_int_n, 1);
  endtask

  task automatic t_read_write();
    setl(1, 1, 0, 13'h0010, 8'hA5); tick();
    chk("R4 drive on write", l_drive, 0);
    setl(1, 1, 1, 13'h0010, 0); tick();
    chk("R2 R3 left read", l_rdata, 8'hA5); chk("R3 drive", l_drive, 1);
    setl(1, 0, 1, 13'h0010, 0); setr(1, 1, 1, 13'h0010, 0); tick();
    chk("R4 oe high", l_drive, 0); chk("R3 right read", r_rdata, 8'hA5);
    setl(0, 1, 1, 13'h0010, 0); tick();
    chk("R4 ce high", l_drive, 0);
    idle();
  endtask

  task automatic t_ce_ignored();
    setr(1, 0, 0, 13'h0020, 8'h11); tick();
    setr(0, 0, 0, 13'h0020, 8'h3C); tick();
    setr(1, 1, 1, 13'h0020, 0); tick();
    chk("R12 ce high write", r_rdata, 8'h11);
    idle();
  endtask

  task automatic t_concurrent();
    setr(1, 0, 0, 13'h0030, 8'h22); tick();
    setl(1, 0, 0, 13'h0030, 8'h77); setr(1, 1, 1, 13'h0030, 0); tick();
    chk("R5 old data", r_rdata, 8'h22);
    setl(1, 0, 0, 13'h0040, 8'h44); setr(1, 0, 0, 13'h0041, 8'h55); tick();
    setl(1, 1, 1, 13'h0041, 0); setr(1, 1, 1, 13'h0030, 0); tick();
    chk("R5 left sees right", l_rdata, 8'h55); chk("R5 new data", r_rdata, 8'h77);
    idle();
  endtask

  task automatic t_mbox_left();
    setr(1, 0, 0, 13'h1FFE, 8'h5A); tick(); idle();
    chk("R6 l_int_n set", l_int_n, 0); chk("R9 r_int_n", r_int_n, 1);
    tick(); chk("R9 l_int_n held", l_int_n, 0);
    setl(1, 0, 1, 13'h1FFE, 0); tick(); idle();
    chk("R7 cleared oe high", l_int_n, 1); chk("R7 drive", l_drive, 0);
    chk("R11 mailbox data", l_rdata, 8'h5A);
  endtask

  task automatic t_mbox_right();
    setl(1, 0, 0, 13'h1FFF, 8'hC3); tick(); idle();
    chk("R8 r_int_n set", r_int_n, 0); chk("R9 l_int_n", l_int_n, 1);
    setr(1, 1, 1, 13'h1FFF, 0); tick(); idle();
    chk("R8 r_int_n clear", r_int_n, 1); chk("R11 mailbox R", r_rdata, 8'hC3);
  endtask

  task automatic t_no_effect();
    setl(1, 0, 0, 13'h1FFE, 8'h01); setr(1, 0, 0, 13'h1FFF, 8'h02); tick(); idle();
    chk("R9 own write L", l_int_n, 1); chk("R9 own write R", r_int_n, 1);
    setl(1, 0, 0, 13'h1FFF, 8'h03); tick(); idle();
    setl(1, 1, 1, 13'h1FFF, 0); setr(1, 1, 1, 13'h1FFE, 0); tick(); idle();
    chk("R9 cross read R", r_int_n, 0); chk("R9 cross read L", l_int_n, 1);
    setr(1, 0, 1, 13'h1FFF, 0); tick(); idle();
    chk("R8 clear again", r_int_n, 1);
  endtask

  task automatic t_priority();
    setr(1, 0, 0, 13'h1FFE, 8'h10); tick();
    setr(1, 0, 0, 13'h1FFE, 8'h20); setl(1, 1, 1, 13'h1FFE, 0); tick(); idle();
    chk("R10 set wins", l_int_n, 0); chk("R5 read old mailbox", l_rdata, 8'h10);
    setl(1, 1, 1, 13'h1FFE, 0); tick(); idle();
    chk("R10 later clear", l_int_n, 1); chk("R11 latest", l_rdata, 8'h20);
  endtask

  initial begin
    #1;
    tick(); tick();
    t_reset();
    t_read_write();
    t_ce_ignored();
    t_concurrent();
    t_mbox_left();
    t_mbox_right();
    t_no_effect();
    t_priority();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule